// File: doc/BRIEF.md
# Eight-Channel Burst DMA Engine

The block copies bytes between a 24-bit memory bus (the A side, a bank byte over a 16-bit offset) and a register bus (the B side), whose address is a fixed base of 0x2100 plus an 8-bit offset. Each of eight channels holds its own control byte, B offset, 16-bit A offset, A bank and 16-bit byte count. Software loads these one byte at a time through a small configuration port. It then writes a channel bitmask to the trigger field.

After a trigger, the engine serves every selected channel to completion, one channel at a time. Each byte takes two cycles: a read strobe on the source bus, then a write strobe on the destination bus. The control byte selects the direction, how the A offset steps and the B register pattern. Reads from A addresses in the protected register windows return zero without touching the bus. When a channel finishes, its A offset register holds the final stepped offset and its count register reads zero.

Top module: `burst_dma_engine`

## Requirements
- R1: When several channels are triggered together, they are served one after another in full, lowest channel index first.
- R2: Control bit 7 selects the direction: 1 reads the B bus and writes the A bus, 0 reads the A bus and writes the B bus.
- R3: With control bit 3 set the A offset stays fixed. With it clear, control bit 4 set steps the offset down by one per byte and bit 4 clear steps it up by one.
- R4: The B address is 0x2100 + offset + k, where k depends on control bits [2:0]. Modes 0, 2 and 6 keep k at 0. Modes 1 and 5 use 0,1 repeating. Modes 3 and 7 use 0,0,1,1 repeating. Mode 4 uses 0,1,2,3 repeating. Each pattern starts again at the beginning of every channel.
- R5: Only the 16-bit A offset steps. It wraps from 0xFFFF to 0x0000 (and the reverse), and the bank byte never changes.
- R6: Each channel moves exactly as many bytes as its count says, even when that ends partway through a pattern group.
- R7: At the end of a channel, its A offset register holds the offset after the last step and its count register reads 0. Its bank, control and B offset registers are unchanged.
- R8: The trigger field reads back the mask while busy and reads 0 once all selected channels have finished.
- R9: An A-bus read whose bank has bit 6 clear (banks 00-3F and 80-BF) and whose offset lies in 0x2100-0x21FF or 0x4000-0x41FF issues no A read strobe, and the byte it supplies is 0.
- R10: A starting count of 0 moves 65536 bytes.
- R11: The configuration port selects a field with cfg_sel_i: 0 control, 1 B offset, 2 A offset low, 3 A offset high, 4 bank, 5 count low, 6 count high, 7 trigger (channel ignored). cfg_rdata_o shows the addressed field at all times. busy_o is high from the cycle after a nonzero trigger write until the last channel has finished, and configuration writes made while busy_o is high have no effect. No bus strobe is active while busy_o is low.
- R12: Each byte is a read strobe in one cycle and a write strobe in the next. Read data is taken in the cycle after the read strobe. At most one strobe is active in any cycle, and write strobes never occur in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | 3 | Channel addressed by the configuration port |
| cfg_sel_i | input | 3 | Field select |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Addressed field read data |
| busy_o | output | 1 | Transfer in progress |
| a_addr_o | output | 24 | A-bus address |
| a_rd_o | output | 1 | A-bus read strobe |
| a_wr_o | output | 1 | A-bus write strobe |
| a_wdata_o | output | 8 | A-bus write data |
| a_rdata_i | input | 8 | A-bus read data, valid the cycle after a_rd_o |
| b_addr_o | output | 16 | B-bus address |
| b_rd_o | output | 1 | B-bus read strobe |
| b_wr_o | output | 1 | B-bus write strobe |
| b_wdata_o | output | 8 | B-bus write data |
| b_rdata_i | input | 8 | B-bus read data, valid the cycle after b_rd_o |

## Verification
Two events can land in the same cycle: the write strobe of a channel's last byte, which also performs the register write-back, and a configuration write from software. The bench waits for the final write strobe of a transfer and, in that exact cycle, drives a write to the same channel's A offset field and a new trigger. It then judges the outcome at the ports. The A offset must read the written-back value, and no further bus activity may follow, which shows that the late software write was ignored because busy_o was still high.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PICK, ST_RD, ST_WR} dma_st_e;

  localparam logic [2:0] F_CTRL = 3'd0;
  localparam logic [2:0] F_BOFF = 3'd1;
  localparam logic [2:0] F_ALO  = 3'd2;
  localparam logic [2:0] F_AHI  = 3'd3;
  localparam logic [2:0] F_BANK = 3'd4;
  localparam logic [2:0] F_CLO  = 3'd5;
  localparam logic [2:0] F_CHI  = 3'd6;
  localparam logic [2:0] F_TRIG = 3'd7;
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
  parameter logic [15:0] B_BASE = 16'h2100
) (
  input  logic [2:0]  mode_i,
  input  logic        fix_i,
  input  logic        dec_i,
  input  logic [1:0]  step_i,
  input  logic [7:0]  boff_i,
  input  logic [7:0]  bank_i,
  input  logic [15:0] addr_i,
  output logic [23:0] a_addr_o,
  output logic [15:0] b_addr_o,
  output logic [15:0] next_addr_o,
  output logic        blocked_o
);
  logic [1:0] pat;

  always_comb begin
    unique case (mode_i)
      3'd1, 3'd5: pat = {1'b0, step_i[0]};
      3'd3, 3'd7: pat = {1'b0, step_i[1]};
      3'd4:       pat = step_i;
      default:    pat = 2'd0;
    endcase
  end

  assign b_addr_o = B_BASE + {8'h00, boff_i} + {14'd0, pat};
  assign a_addr_o = {bank_i, addr_i};

  always_comb begin
    if (fix_i)      next_addr_o = addr_i;
    else if (dec_i) next_addr_o = addr_i - 16'd1;
    else            next_addr_o = addr_i + 16'd1;
  end

  // protected register windows in the low-half banks
  assign blocked_o = !bank_i[6] &&
                     ((addr_i[15:8] == 8'h21) || (addr_i[15:9] == 7'h20));
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [2:0]        sel_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  output logic              start_o,
  output logic [NUM_CH-1:0] mask_o,
  input  logic [CH_W-1:0]   view_ch_i,
  output logic              v_dir_o,
  output logic              v_fix_o,
  output logic              v_dec_o,
  output logic [2:0]        v_mode_o,
  output logic [7:0]        v_boff_o,
  output logic [7:0]        v_bank_o,
  output logic [15:0]       v_addr_o,
  output logic [15:0]       v_cnt_o,
  input  logic              wb_en_i,
  input  logic [CH_W-1:0]   wb_ch_i,
  input  logic [15:0]       wb_addr_i
);
  logic [7:0]  ctrl_q [NUM_CH];
  logic [7:0]  boff_q [NUM_CH];
  logic [7:0]  bank_q [NUM_CH];
  logic [15:0] addr_q [NUM_CH];
  logic [15:0] cnt_q  [NUM_CH];
  logic [7:0]  trig_q;
  logic        wr_ok;

  assign wr_ok   = we_i && !busy_i;
  assign start_o = wr_ok && (sel_i == F_TRIG) && (wdata_i[NUM_CH-1:0] != '0);
  assign mask_o  = wdata_i[NUM_CH-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = wr_ok && (ch_i == CH_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_q[g] <= '0;
        boff_q[g] <= '0;
        bank_q[g] <= '0;
        addr_q[g] <= '0;
        cnt_q[g]  <= '0;
      end else if (wb_en_i && (wb_ch_i == CH_W'(g))) begin
        addr_q[g] <= wb_addr_i;
        cnt_q[g]  <= '0;
      end else if (hit) begin
        unique case (sel_i)
          F_CTRL: ctrl_q[g]       <= wdata_i;
          F_BOFF: boff_q[g]       <= wdata_i;
          F_ALO:  addr_q[g][7:0]  <= wdata_i;
          F_AHI:  addr_q[g][15:8] <= wdata_i;
          F_BANK: bank_q[g]       <= wdata_i;
          F_CLO:  cnt_q[g][7:0]   <= wdata_i;
          F_CHI:  cnt_q[g][15:8]  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      trig_q <= '0;
    else if (start_o) trig_q <= wdata_i;
    else if (done_i)  trig_q <= '0;
  end

  always_comb begin
    unique case (sel_i)
      F_CTRL:  rdata_o = ctrl_q[ch_i];
      F_BOFF:  rdata_o = boff_q[ch_i];
      F_ALO:   rdata_o = addr_q[ch_i][7:0];
      F_AHI:   rdata_o = addr_q[ch_i][15:8];
      F_BANK:  rdata_o = bank_q[ch_i];
      F_CLO:   rdata_o = cnt_q[ch_i][7:0];
      F_CHI:   rdata_o = cnt_q[ch_i][15:8];
      default: rdata_o = trig_q;
    endcase
  end

  assign v_dir_o  = ctrl_q[view_ch_i][7];
  assign v_dec_o  = ctrl_q[view_ch_i][4];
  assign v_fix_o  = ctrl_q[view_ch_i][3];
  assign v_mode_o = ctrl_q[view_ch_i][2:0];
  assign v_boff_o = boff_q[view_ch_i];
  assign v_bank_o = bank_q[view_ch_i];
  assign v_addr_o = addr_q[view_ch_i];
  assign v_cnt_o  = cnt_q[view_ch_i];
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NUM_CH-1:0] mask_i,
  output logic [CH_W-1:0]   view_ch_o,
  input  logic              v_dir_i,
  input  logic [15:0]       v_addr_i,
  input  logic [15:0]       v_cnt_i,
  input  logic [15:0]       next_addr_i,
  input  logic              blocked_i,
  input  logic [7:0]        a_rdata_i,
  input  logic [7:0]        b_rdata_i,
  output logic [15:0]       addr_o,
  output logic [1:0]        step_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              wb_en_o,
  output logic [CH_W-1:0]   wb_ch_o,
  output logic [15:0]       wb_addr_o,
  output logic              a_rd_o,
  output logic              a_wr_o,
  output logic              b_rd_o,
  output logic              b_wr_o,
  output logic [7:0]        wdata_o
);
  dma_st_e           st_q;
  logic [NUM_CH-1:0] pend_q;
  logic [CH_W-1:0]   cur_q, low;
  logic [15:0]       addr_q;
  logic [16:0]       rem_q;
  logic [1:0]        step_q;
  logic              blk_q;
  logic              last;

  always_comb begin
    low = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (pend_q[i]) low = CH_W'(i);
  end

  assign last = (rem_q == 17'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
      cur_q  <= '0;
      addr_q <= '0;
      rem_q  <= '0;
      step_q <= '0;
      blk_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          pend_q <= mask_i;
          st_q   <= ST_PICK;
        end
        ST_PICK: if (pend_q == '0) begin
          st_q <= ST_IDLE;
        end else begin
          cur_q  <= low;
          addr_q <= v_addr_i;
          rem_q  <= (v_cnt_i == 16'd0) ? 17'h10000 : {1'b0, v_cnt_i};
          step_q <= '0;
          st_q   <= ST_RD;
        end
        ST_RD: begin
          blk_q <= !v_dir_i && blocked_i;
          st_q  <= ST_WR;
        end
        ST_WR: begin
          addr_q <= next_addr_i;
          rem_q  <= rem_q - 17'd1;
          step_q <= step_q + 2'd1;
          if (last) begin
            pend_q[cur_q] <= 1'b0;
            st_q          <= ST_PICK;
          end else begin
            st_q <= ST_RD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign view_ch_o = (st_q == ST_PICK) ? low : cur_q;
  assign addr_o    = addr_q;
  assign step_o    = step_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = (st_q == ST_PICK) && (pend_q == '0);
  assign wb_en_o   = (st_q == ST_WR) && last;
  assign wb_ch_o   = cur_q;
  assign wb_addr_o = next_addr_i;

  assign a_rd_o  = (st_q == ST_RD) && !v_dir_i && !blocked_i;
  assign b_rd_o  = (st_q == ST_RD) && v_dir_i;
  assign b_wr_o  = (st_q == ST_WR) && !v_dir_i;
  assign a_wr_o  = (st_q == ST_WR) && v_dir_i;
  assign wdata_o = v_dir_i ? b_rdata_i : (blk_q ? 8'h00 : a_rdata_i);
endmodule

// File: rtl/burst_dma_engine.sv
module burst_dma_engine #(
  parameter int          NUM_CH = 8,
  parameter logic [15:0] B_BASE = 16'h2100,
  localparam int         CH_W   = $clog2(NUM_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [CH_W-1:0] cfg_ch_i,
  input  logic [2:0]      cfg_sel_i,
  input  logic [7:0]      cfg_wdata_i,
  output logic [7:0]      cfg_rdata_o,
  output logic            busy_o,
  output logic [23:0]     a_addr_o,
  output logic            a_rd_o,
  output logic            a_wr_o,
  output logic [7:0]      a_wdata_o,
  input  logic [7:0]      a_rdata_i,
  output logic [15:0]     b_addr_o,
  output logic            b_rd_o,
  output logic            b_wr_o,
  output logic [7:0]      b_wdata_o,
  input  logic [7:0]      b_rdata_i
);
  logic              start, done, wb_en;
  logic [NUM_CH-1:0] mask;
  logic [CH_W-1:0]   view_ch, wb_ch;
  logic              v_dir, v_fix, v_dec;
  logic [2:0]        v_mode;
  logic [7:0]        v_boff, v_bank, wdata;
  logic [15:0]       v_addr, v_cnt, wb_addr, next_addr, cur_addr;
  logic [1:0]        step;
  logic              blocked;

  dma_regfile #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .ch_i(cfg_ch_i), .sel_i(cfg_sel_i),
    .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .busy_i(busy_o), .done_i(done), .start_o(start), .mask_o(mask),
    .view_ch_i(view_ch), .v_dir_o(v_dir), .v_fix_o(v_fix), .v_dec_o(v_dec),
    .v_mode_o(v_mode), .v_boff_o(v_boff), .v_bank_o(v_bank),
    .v_addr_o(v_addr), .v_cnt_o(v_cnt),
    .wb_en_i(wb_en), .wb_ch_i(wb_ch), .wb_addr_i(wb_addr)
  );

  dma_addr_unit #(.B_BASE(B_BASE)) u_addr (
    .mode_i(v_mode), .fix_i(v_fix), .dec_i(v_dec), .step_i(step),
    .boff_i(v_boff), .bank_i(v_bank), .addr_i(cur_addr),
    .a_addr_o, .b_addr_o, .next_addr_o(next_addr), .blocked_o(blocked)
  );

  dma_seq #(.NUM_CH(NUM_CH)) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .mask_i(mask), .view_ch_o(view_ch),
    .v_dir_i(v_dir), .v_addr_i(v_addr), .v_cnt_i(v_cnt),
    .next_addr_i(next_addr), .blocked_i(blocked),
    .a_rdata_i, .b_rdata_i,
    .addr_o(cur_addr), .step_o(step), .busy_o, .done_o(done),
    .wb_en_o(wb_en), .wb_ch_o(wb_ch), .wb_addr_o(wb_addr),
    .a_rd_o, .a_wr_o, .b_rd_o, .b_wr_o, .wdata_o(wdata)
  );

  assign a_wdata_o = wdata;
  assign b_wdata_o = wdata;
endmodule

// File: rtl/dma_checker.sv
module dma_checker #(
  parameter logic [15:0] B_BASE = 16'h2100
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        a_rd_o,
  input logic        a_wr_o,
  input logic        b_rd_o,
  input logic        b_wr_o,
  input logic [23:0] a_addr_o,
  input logic [15:0] b_addr_o
);
  logic any_wr;
  assign any_wr = a_wr_o || b_wr_o;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(a_rd_o || a_wr_o || b_rd_o || b_wr_o)); // R11

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({a_rd_o, a_wr_o, b_rd_o, b_wr_o}) <= 1); // R12

  AST_WR_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_wr |=> !any_wr); // R12

  AST_NO_PROT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_rd_o |-> (a_addr_o[22] || !((a_addr_o[15:8] == 8'h21) ||
                                  (a_addr_o[15:9] == 7'h20)))); // R9

  AST_B_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_rd_o || b_wr_o) |-> ((b_addr_o >= B_BASE) &&
                            (b_addr_o <= B_BASE + 16'h0102))); // R4
endmodule

bind burst_dma_engine dma_checker #(.B_BASE(B_BASE)) u_chk (
  .clk_i, .rst_ni, .busy_o, .a_rd_o, .a_wr_o, .b_rd_o, .b_wr_o,
  .a_addr_o, .b_addr_o
);

// File: tb/burst_dma_engine_tb.sv
module burst_dma_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_ch = '0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        busy;
  logic [23:0] a_addr;
  logic        a_rd, a_wr;
  logic [7:0]  a_wdata;
  logic [7:0]  a_rdata = '0;
  logic [15:0] b_addr;
  logic        b_rd, b_wr;
  logic [7:0]  b_wdata;
  logic [7:0]  b_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  burst_dma_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .busy_o(busy),
    .a_addr_o(a_addr), .a_rd_o(a_rd), .a_wr_o(a_wr), .a_wdata_o(a_wdata),
    .a_rdata_i(a_rdata),
    .b_addr_o(b_addr), .b_rd_o(b_rd), .b_wr_o(b_wr), .b_wdata_o(b_wdata),
    .b_rdata_i(b_rdata)
  );

  function automatic logic [7:0] apat(input logic [23:0] x);
    return x[23:16] ^ x[15:8] ^ x[7:0] ^ 8'h5A;
  endfunction

  // bus models and traffic log
  logic [15:0] bw_addr [256];
  logic [7:0]  bw_data [256];
  logic [23:0] aw_addr [256];
  logic [7:0]  aw_data [256];
  int bw_n = 0, aw_n = 0, ar_n = 0, br_n = 0;

  always @(posedge clk) begin
    if (a_rd) begin a_rdata <= apat(a_addr); ar_n <= ar_n + 1; end
    if (b_rd) begin b_rdata <= b_addr[7:0] ^ 8'hC3; br_n <= br_n + 1; end
    if (b_wr) begin
      if (bw_n < 256) begin bw_addr[bw_n] <= b_addr; bw_data[bw_n] <= b_wdata; end
      bw_n <= bw_n + 1;
    end
    if (a_wr) begin
      if (aw_n < 256) begin aw_addr[aw_n] <= a_addr; aw_data[aw_n] <= a_wdata; end
      aw_n <= aw_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] ch, input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [2:0] ch, input logic [2:0] sel, output logic [7:0] d);
    @(negedge clk);
    cfg_ch = ch; cfg_sel = sel;
    #1 d = cfg_rdata;
  endtask

  task automatic setup(input logic [2:0] ch, input logic [7:0] ctrl, input logic [7:0] boff,
                       input logic [15:0] addr, input logic [7:0] bank, input logic [15:0] cnt);
    cfg_wr(ch, 3'd0, ctrl);
    cfg_wr(ch, 3'd1, boff);
    cfg_wr(ch, 3'd2, addr[7:0]);
    cfg_wr(ch, 3'd3, addr[15:8]);
    cfg_wr(ch, 3'd4, bank);
    cfg_wr(ch, 3'd5, cnt[7:0]);
    cfg_wr(ch, 3'd6, cnt[15:8]);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 140000) begin @(negedge clk); n++; end
  endtask

  task automatic run(input logic [7:0] mask);
    cfg_wr(3'd0, 3'd7, mask);
    wait_idle();
    @(negedge clk);
  endtask

  task automatic rd16(input logic [2:0] ch, input logic [2:0] sel_lo, output logic [15:0] v);
    logic [7:0] lo, hi;
    cfg_rd(ch, sel_lo, lo);
    cfg_rd(ch, sel_lo + 3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk(busy == 1'b0, "R11 reset busy", busy, 0);
    cfg_rd(3'd0, 3'd7, d);
    chk(d == 8'h00, "R8 reset trigger", d, 0);
    cfg_rd(3'd3, 3'd2, d);
    chk(d == 8'h00, "R11 reset addr", d, 0);
  endtask

  task automatic t_mode4_inc();
    int b0 = bw_n;
    logic [15:0] v;
    logic [7:0] d;
    setup(3'd2, 8'h04, 8'h18, 16'h1000, 8'h7E, 16'd6);
    cfg_wr(3'd0, 3'd7, 8'h04);
    cfg_rd(3'd0, 3'd7, d);
    chk(d == 8'h04 && busy, "R8 trigger while busy", d, 8'h04);
    wait_idle(); @(negedge clk);
    chk(bw_n - b0 == 6, "R6 mode4 byte count", bw_n - b0, 6);
    for (int i = 0; i < 6; i++) begin
      logic [15:0] ea = 16'h2118 + 16'(i % 4);
      logic [7:0] ed = apat({8'h7E, 16'h1000 + 16'(i)});
      chk(bw_addr[b0+i] == ea, "R4 mode4 b addr", bw_addr[b0+i], ea);
      chk(bw_data[b0+i] == ed, "R3 inc data", bw_data[b0+i], ed);
    end
    rd16(3'd2, 3'd2, v);
    chk(v == 16'h1006, "R7 writeback addr", v, 16'h1006);
    rd16(3'd2, 3'd5, v);
    chk(v == 16'h0000, "R7 count cleared", v, 0);
    cfg_rd(3'd0, 3'd7, d);
    chk(d == 8'h00, "R8 trigger done", d, 0);
  endtask

  task automatic t_mode3_dec_wrap();
    int b0 = bw_n;
    logic [15:0] v;
    logic [7:0] d;
    logic [15:0] ad [5] = '{16'h0002, 16'h0001, 16'h0000, 16'hFFFF, 16'hFFFE};
    logic [1:0]  ko [5] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd0};
    setup(3'd3, 8'h13, 8'h40, 16'h0002, 8'h7F, 16'd5);
    run(8'h08);
    chk(bw_n - b0 == 5, "R6 partial group", bw_n - b0, 5);
    for (int i = 0; i < 5; i++) begin
      logic [15:0] ea = 16'h2140 + {14'd0, ko[i]};
      logic [7:0] ed = apat({8'h7F, ad[i]});
      chk(bw_addr[b0+i] == ea, "R4 mode3 b addr", bw_addr[b0+i], ea);
      chk(bw_data[b0+i] == ed, "R5 dec wrap data", bw_data[b0+i], ed);
    end
    rd16(3'd3, 3'd2, v);
    chk(v == 16'hFFFD, "R5 wrapped writeback", v, 16'hFFFD);
    cfg_rd(3'd3, 3'd4, d);
    chk(d == 8'h7F, "R7 bank kept", d, 8'h7F);
  endtask

  task automatic t_mode1_fixed();
    int b0 = bw_n;
    logic [15:0] v;
    setup(3'd1, 8'h19, 8'h22, 16'h3456, 8'h7E, 16'd3);
    run(8'h02);
    for (int i = 0; i < 3; i++) begin
      logic [15:0] ea = 16'h2122 + 16'(i % 2);
      chk(bw_addr[b0+i] == ea, "R4 mode1 b addr", bw_addr[b0+i], ea);
      chk(bw_data[b0+i] == apat(24'h7E3456), "R3 fixed data", bw_data[b0+i], apat(24'h7E3456));
    end
    rd16(3'd1, 3'd2, v);
    chk(v == 16'h3456, "R3 fixed writeback", v, 16'h3456);
  endtask

  task automatic t_b_to_a();
    int a0 = aw_n, r0 = ar_n, w0 = bw_n, q0 = br_n;
    setup(3'd4, 8'h80, 8'h80, 16'h0100, 8'h7E, 16'd3);
    run(8'h10);
    chk(aw_n - a0 == 3 && bw_n == w0, "R2 write side", aw_n - a0, 3);
    chk(ar_n == r0 && br_n - q0 == 3, "R2 read side", br_n - q0, 3);
    for (int i = 0; i < 3; i++) begin
      logic [23:0] ea = {8'h7E, 16'h0100 + 16'(i)};
      chk(aw_addr[a0+i] == ea, "R2 a write addr", aw_addr[a0+i], ea);
      chk(aw_data[a0+i] == 8'h43, "R2 a write data", aw_data[a0+i], 8'h43);
    end
  endtask

  task automatic t_priority();
    int b0 = bw_n;
    setup(3'd5, 8'h00, 8'h55, 16'h0000, 8'h7E, 16'd2);
    setup(3'd1, 8'h00, 8'h11, 16'h0000, 8'h7E, 16'd2);
    run(8'h22);
    chk(bw_n - b0 == 4, "R1 total bytes", bw_n - b0, 4);
    chk(bw_addr[b0] == 16'h2111 && bw_addr[b0+1] == 16'h2111, "R1 low channel first", bw_addr[b0], 16'h2111);
    chk(bw_addr[b0+2] == 16'h2155 && bw_addr[b0+3] == 16'h2155, "R1 high channel second", bw_addr[b0+2], 16'h2155);
  endtask

  task automatic t_blocked();
    int b0 = bw_n, r0 = ar_n;
    setup(3'd6, 8'h00, 8'h00, 16'h20FF, 8'h00, 16'd3);
    run(8'h40);
    chk(ar_n - r0 == 1, "R9 read strobes", ar_n - r0, 1);
    chk(bw_data[b0] == apat(24'h0020FF), "R9 open byte", bw_data[b0], apat(24'h0020FF));
    chk(bw_data[b0+1] == 8'h00 && bw_data[b0+2] == 8'h00, "R9 blocked zero", bw_data[b0+1], 0);
    b0 = bw_n; r0 = ar_n;
    setup(3'd6, 8'h00, 8'h00, 16'h41FF, 8'h80, 16'd2);
    run(8'h40);
    chk(ar_n - r0 == 1 && bw_data[b0] == 8'h00, "R9 bank80 window", bw_data[b0], 0);
    chk(bw_data[b0+1] == apat(24'h804200), "R9 past window", bw_data[b0+1], apat(24'h804200));
    b0 = bw_n; r0 = ar_n;
    setup(3'd6, 8'h00, 8'h00, 16'h2100, 8'h40, 16'd1);
    run(8'h40);
    chk(ar_n - r0 == 1 && bw_data[b0] == apat(24'h402100), "R9 bank40 open", bw_data[b0], apat(24'h402100));
  endtask

  task automatic t_busy_collision();
    int b0 = bw_n;
    logic [15:0] v;
    setup(3'd0, 8'h00, 8'h05, 16'h0200, 8'h7E, 16'd4);
    setup(3'd7, 8'h00, 8'h07, 16'h0000, 8'h7E, 16'd1);
    cfg_wr(3'd0, 3'd7, 8'h01);
    cfg_wr(3'd0, 3'd5, 8'h09);             // mid-transfer write to count
    while (bw_n - b0 < 3) @(negedge clk);
    while (!b_wr) @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 3'd0; cfg_sel = 3'd2; cfg_wdata = 8'hAA;
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 3'd0; cfg_sel = 3'd7; cfg_wdata = 8'h80;
    @(negedge clk);
    cfg_we = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    chk(bw_n - b0 == 4, "R11 no extra bytes", bw_n - b0, 4);
    rd16(3'd0, 3'd2, v);
    chk(v == 16'h0204, "R11 late write ignored", v, 16'h0204);
    rd16(3'd0, 3'd5, v);
    chk(v == 16'h0000, "R11 busy count write ignored", v, 0);
  endtask

  task automatic t_full_count();
    int b0 = bw_n;
    logic [15:0] v;
    setup(3'd2, 8'h00, 8'h30, 16'h0000, 8'h7E, 16'd0);
    run(8'h04);
    chk(bw_n - b0 == 65536, "R10 zero count bytes", bw_n - b0, 65536);
    rd16(3'd2, 3'd2, v);
    chk(v == 16'h0000, "R10 full wrap writeback", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode4_inc();
    t_mode3_dec_wrap();
    t_mode1_fixed();
    t_b_to_a();
    t_priority();
    t_blocked();
    t_busy_collision();
    t_full_count();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R11 act=running exp=idle");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule